// File: doc/BRIEF.md
# SPI Master Controller

This block is a full-duplex serial peripheral bus master for up to five slave devices. Software programs it through a small word-wide register port. It writes a 32-bit transmit word, then picks the transfer length (8, 16 or 32 bits), the clock polarity and phase (modes 0 to 3), the bit order, the clock divider and the target select. It then issues a start command. The block generates the serial clock and shifts the word out on the master-out line. On every serial clock cycle it also captures one bit from the master-in line into the same shift path. No further host action is needed until the transfer ends.

At the end of a transfer, the received word is placed right-aligned in a readable register and a sticky completion flag is set. The flag drives an interrupt output, which an enable bit can mask. Each of the five active-low selects is asserted automatically while its transfer runs. A hold bit keeps the select low after the transfer, so several back-to-back transfers form one longer frame on the bus.

Top module: `spi_master_ctl`

## Requirements
- R1: After reset, all selects are high, sclk_o and mosi_o are low, irq_o is low, and the control, status and receive registers read zero.
- R2: The register map is as follows. Control is at address 0: bits [1:0] length (0 = 8, 1 = 16, 2 or 3 = 32), bit 2 polarity, bit 3 phase, bit 4 LSB-first, bits [7:5] select index, bit 8 hold, bit 9 interrupt enable, bits [23:16] divider N. Transmit is at address 1. Receive is at address 2. Status is at address 3, with bit 0 busy and bit 1 done flag. Command is at address 4, where bit 0 means start.
- R3: Writing 1 to the start bit while idle latches the settings and the transmit word. Busy reads 1 from the next cycle, for exactly 2·L·H cycles, where L is the length and H is the half period.
- R4: The half period H is N system clocks for N ≥ 1 and 1 clock for N = 0. While idle, sclk_o sits at the polarity bit. The first edge comes H cycles after the start, and 2·L edges occur in total.
- R5: With phase 0, the first bit appears on mosi_o at the start, later bits change on trailing edges, and the master samples on leading edges. With phase 1, bits change on leading edges and the master samples on trailing edges. mosi_o is 0 while idle.
- R6: With LSB-first set, transmit bit 0 goes out first. Otherwise bit L-1 goes out first. The received bits are ordered the same way.
- R7: The received word is right-aligned with zero upper bits and is updated when busy falls.
- R8: A select index k below 5 drives cs_n_o[k] low from the start cycle onward. Indices 5 to 7 assert no select. At most one select is ever low, and none changes during a transfer.
- R9: If hold is 1 when a transfer ends, its select stays low. While idle, a select that is being held is released one cycle after hold is seen at 0.
- R10: The done flag sets when a transfer ends and is cleared by writing 1 to status bit 1. A set in the same cycle as a clear wins. irq_o equals the flag AND the interrupt enable bit.
- R11: A start command or a control write issued while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| miso_i | input | 1 | Serial data from the slaves |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slaves |
| cs_n_o | output | 5 | Active-low slave selects |
| irq_o | output | 1 | Transfer-complete interrupt |

## Verification
A write is sampled on the clock edge that follows it. Busy and the select therefore change one cycle after the start write. The first serial clock edge is due H cycles after the start, and busy, the done flag and the receive register all change together after 2·L·H cycles. A behavioural model in the bench keeps a per-transfer cycle count and derives the clock level, the data bit and the select from it. The model is updated at each rising edge, and the outputs are compared at every falling edge, so each comparison sees both sides after the same edge. The busy length is also measured directly through status reads and checked against 2·L·H.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NSEL   = 5;
  localparam int unsigned DIV_W  = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned LEN_W  = $clog2(DATA_W) + 1;
  localparam int unsigned CNT_W  = $clog2(2 * DATA_W);

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_TX   = 3'd1;
  localparam logic [ADDR_W-1:0] A_RX   = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd4;

  typedef enum logic [1:0] {
    LEN_8  = 2'd0,
    LEN_16 = 2'd1,
    LEN_32 = 2'd2,
    LEN_XX = 2'd3
  } len_e;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             hold;
    logic [SEL_W-1:0] sel;
    logic             lsb_first;
    logic             cpha;
    logic             cpol;
    len_e             len;
  } cfg_t;

  function automatic logic [LEN_W-1:0] len_bits(input len_e l);
    case (l)
      LEN_8:   return LEN_W'(8);
      LEN_16:  return LEN_W'(16);
      default: return LEN_W'(DATA_W);
    endcase
  endfunction

  // reverse the low n bits, clear the rest
  function automatic logic [DATA_W-1:0] rev_low(input logic [DATA_W-1:0] d,
                                                input logic [LEN_W-1:0] n);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(n)) r[i] = d[int'(n) - 1 - i];
    return r;
  endfunction
endpackage

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_mst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_i,
  output logic              start_o,
  output cfg_t              cfg_o,
  output logic [DATA_W-1:0] tx_o,
  output logic              irq_o
);
  cfg_t              cfg_q;
  logic              irq_en_q;
  logic              flag_q;
  logic [DATA_W-1:0] tx_q;

  logic wr_ctrl, wr_tx, wr_stat, wr_cmd;
  assign wr_ctrl = we_i && (addr_i == A_CTRL);
  assign wr_tx   = we_i && (addr_i == A_TX);
  assign wr_stat = we_i && (addr_i == A_STAT);
  assign wr_cmd  = we_i && (addr_i == A_CMD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      irq_en_q <= 1'b0;
      flag_q   <= 1'b0;
      tx_q     <= '0;
    end else begin
      if (wr_ctrl && !busy_i) begin
        cfg_q.len       <= len_e'(wdata_i[1:0]);
        cfg_q.cpol      <= wdata_i[2];
        cfg_q.cpha      <= wdata_i[3];
        cfg_q.lsb_first <= wdata_i[4];
        cfg_q.sel       <= wdata_i[7:5];
        cfg_q.hold      <= wdata_i[8];
        irq_en_q        <= wdata_i[9];
        cfg_q.div       <= wdata_i[23:16];
      end
      if (wr_tx) tx_q <= wdata_i;
      if (done_i) flag_q <= 1'b1;
      else if (wr_stat && wdata_i[1]) flag_q <= 1'b0;
    end
  end

  assign start_o = wr_cmd && wdata_i[0] && !busy_i;
  assign cfg_o   = cfg_q;
  assign tx_o    = tx_q;
  assign irq_o   = flag_q && irq_en_q;

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = {8'b0, cfg_q.div, 6'b0, irq_en_q, cfg_q.hold, cfg_q.sel,
                          cfg_q.lsb_first, cfg_q.cpha, cfg_q.cpol, cfg_q.len};
      A_TX:    rdata_o = tx_q;
      A_RX:    rdata_o = rx_i;
      A_STAT:  rdata_o = {30'b0, flag_q, busy_i};
      default: rdata_o = '0;
    endcase
  end

  // R10
  a_r10_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> flag_q);
  a_r10_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat && wdata_i[1] && !done_i |=> !flag_q);
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_mst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  len_e              len_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              lsb_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int unsigned BUSY_LIM = 2 * DATA_W * (2 ** DIV_W);
  localparam int unsigned BC_W     = $clog2(BUSY_LIM) + 1;

  logic [DIV_W-1:0]  half_q, hc_q;
  logic [CNT_W-1:0]  ec_q, last_q;
  logic [LEN_W-1:0]  nb_q, nb_w;
  logic              busy_q, tog_q, mosi_q, cpol_q, cpha_q, lsb_q;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q, rx_q;
  logic [DATA_W-1:0] tx_norm, rx_nx, rx_al;
  logic              edge_w, last_w, smp_w, sft_w;

  assign nb_w    = len_bits(len_i);
  // bit to send next always sits at position 0
  assign tx_norm = lsb_i ? tx_i : rev_low(tx_i, nb_w);

  assign edge_w = busy_q && (hc_q == half_q);
  assign last_w = edge_w && (ec_q == last_q);
  assign smp_w  = edge_w && (ec_q[0] == cpha_q);
  assign sft_w  = edge_w && (ec_q[0] != cpha_q) && !last_w;

  // first captured bit ends at position L-1
  assign rx_nx = smp_w ? {rx_sh_q[DATA_W-2:0], miso_i} : rx_sh_q;
  assign rx_al = lsb_q ? rev_low(rx_nx, nb_q) : rx_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      half_q  <= '0;
      hc_q    <= '0;
      ec_q    <= '0;
      last_q  <= '0;
      nb_q    <= '0;
      tog_q   <= 1'b0;
      mosi_q  <= 1'b0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      lsb_q   <= 1'b0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      rx_q    <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      hc_q    <= '0;
      ec_q    <= '0;
      tog_q   <= 1'b0;
      half_q  <= (div_i == '0) ? '0 : div_i - DIV_W'(1);
      last_q  <= CNT_W'({nb_w, 1'b0} - (LEN_W+1)'(1));
      nb_q    <= nb_w;
      cpol_q  <= cpol_i;
      cpha_q  <= cpha_i;
      lsb_q   <= lsb_i;
      rx_sh_q <= '0;
      if (cpha_i) begin
        mosi_q  <= 1'b0;
        tx_sh_q <= tx_norm;
      end else begin
        mosi_q  <= tx_norm[0];
        tx_sh_q <= tx_norm >> 1;
      end
    end else if (busy_q) begin
      if (edge_w) begin
        hc_q  <= '0;
        ec_q  <= ec_q + CNT_W'(1);
        tog_q <= ~tog_q;
      end else begin
        hc_q  <= hc_q + DIV_W'(1);
      end
      if (smp_w) rx_sh_q <= rx_nx;
      if (sft_w) begin
        mosi_q  <= tx_sh_q[0];
        tx_sh_q <= tx_sh_q >> 1;
      end
      if (last_w) begin
        busy_q <= 1'b0;
        mosi_q <= 1'b0;
        rx_q   <= rx_al;
      end
    end
  end

  assign sclk_o = busy_q ? (cpol_q ^ tog_q) : cpol_i;
  assign mosi_o = mosi_q;
  assign busy_o = busy_q;
  assign done_o = last_w;
  assign rx_o   = rx_q;

  logic [BC_W-1:0] bcnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bcnt_q <= '0;
    else if (start_i) bcnt_q <= '0;
    else if (busy_q)  bcnt_q <= bcnt_q + BC_W'(1);
  end

  a_r11_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  a_r4_edge_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_w && (half_q != '0) |=> !edge_w);
  a_r3_busy_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> bcnt_q < BC_W'(BUSY_LIM));
endmodule

// File: rtl/spi_sel_ctl.sv
module spi_sel_ctl
  import spi_mst_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             busy_i,
  input  logic             hold_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [NSEL-1:0]  cs_n_o
);
  logic             on_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= 1'b0;
      sel_q <= '0;
    end else if (start_i) begin
      on_q  <= 1'b1;
      sel_q <= sel_i;
    end else if (done_i) begin
      on_q  <= hold_i;
    end else if (!busy_i && !hold_i) begin
      on_q  <= 1'b0;
    end
  end

  for (genvar g = 0; g < NSEL; g++) begin : g_cs
    assign cs_n_o[g] = !(on_q && (sel_q == SEL_W'(g)));
  end

  // R8
  a_r8_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  a_r8_cs_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> $stable(cs_n_o));
endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl
  import spi_mst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [NSEL-1:0]   cs_n_o,
  output logic              irq_o
);
  cfg_t              cfg_w;
  logic [DATA_W-1:0] tx_w, rx_w;
  logic              start_w, busy_w, done_w;

  spi_host_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .busy_i  (busy_w),
    .done_i  (done_w),
    .rx_i    (rx_w),
    .start_o (start_w),
    .cfg_o   (cfg_w),
    .tx_o    (tx_w),
    .irq_o   (irq_o)
  );

  spi_xfer_engine u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_w),
    .len_i   (cfg_w.len),
    .cpol_i  (cfg_w.cpol),
    .cpha_i  (cfg_w.cpha),
    .lsb_i   (cfg_w.lsb_first),
    .div_i   (cfg_w.div),
    .tx_i    (tx_w),
    .miso_i  (miso_i),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .busy_o  (busy_w),
    .done_o  (done_w),
    .rx_o    (rx_w)
  );

  spi_sel_ctl u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_w),
    .done_i  (done_w),
    .busy_i  (busy_w),
    .hold_i  (cfg_w.hold),
    .sel_i   (cfg_w.sel),
    .cs_n_o  (cs_n_o)
  );
endmodule

// File: tb/spi_master_ctl_tb_top.sv
`timescale 1ns/1ps
module spi_master_ctl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        miso_i = 1'b0;
  logic        sclk_o, mosi_o, irq_o;
  logic [4:0]  cs_n_o;

  always #2.5 clk_i = ~clk_i;

  spi_master_ctl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .miso_i(miso_i),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o), .irq_o(irq_o)
  );

  int n_chk = 0, n_fail = 0;
  bit run_done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!run_done) begin
      run_done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // slave data source
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk_i) begin
    lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso_i <= lfsr[7];
  end

  // ---------------- behavioural model ----------------
  int m_len, m_cpol, m_cpha, m_lsb, m_sel, m_hold, m_irqen, m_div;
  logic [31:0] m_tx, m_rx;
  bit m_flag, m_busy, m_cs_on;
  int m_cyc, m_H, m_L, m_edges, x_cpol, x_cpha, x_lsb, x_sel;
  logic [31:0] m_txb;
  bit m_rxq[$];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_len = 0; m_cpol = 0; m_cpha = 0; m_lsb = 0; m_sel = 0; m_hold = 0; m_irqen = 0; m_div = 0;
      m_tx = 0; m_rx = 0; m_flag = 0; m_busy = 0; m_cs_on = 0; m_cyc = 0; m_H = 1; m_L = 8;
      m_edges = 0; x_cpol = 0; x_cpha = 0; x_lsb = 0; x_sel = 0; m_txb = 0; m_rxq.delete();
    end else begin
      bit busy_b, set_f, clr_f;
      busy_b = m_busy; set_f = 0; clr_f = 0;
      if (m_busy) begin
        m_cyc++;
        if (m_cyc % m_H == 0) begin
          int e;
          e = m_cyc / m_H - 1;
          if (e % 2 == x_cpha) m_rxq.push_back(miso_i);
          m_edges = e + 1;
          if (e == 2 * m_L - 1) begin
            m_busy = 0; set_f = 1; m_cs_on = (m_hold != 0);
            m_rx = 0;
            for (int j = 0; j < m_L; j++)
              if (x_lsb != 0) m_rx[j] = m_rxq[j]; else m_rx[m_L-1-j] = m_rxq[j];
          end
        end
      end else if (m_hold == 0) m_cs_on = 0;
      if (we_i) begin
        case (addr_i)
          3'd0: if (!busy_b) begin
            m_len = wdata_i[1:0]; m_cpol = wdata_i[2]; m_cpha = wdata_i[3]; m_lsb = wdata_i[4];
            m_sel = wdata_i[7:5]; m_hold = wdata_i[8]; m_irqen = wdata_i[9]; m_div = wdata_i[23:16];
          end
          3'd1: m_tx = wdata_i;
          3'd3: if (wdata_i[1]) clr_f = 1;
          3'd4: if (wdata_i[0] && !busy_b) begin
            m_busy = 1; m_cyc = 0; m_edges = 0; m_cs_on = 1;
            m_L = (m_len == 0) ? 8 : (m_len == 1) ? 16 : 32;
            m_H = (m_div == 0) ? 1 : m_div;
            x_cpol = m_cpol; x_cpha = m_cpha; x_lsb = m_lsb; x_sel = m_sel;
            m_rxq.delete(); m_txb = 0;
            for (int j = 0; j < m_L; j++) m_txb[j] = (m_lsb != 0) ? m_tx[j] : m_tx[m_L-1-j];
          end
          default: ;
        endcase
      end
      if (set_f) m_flag = 1; else if (clr_f) m_flag = 0;
    end
  end

  function automatic logic exp_sclk();
    if (m_busy) return logic'(x_cpol[0] ^ m_edges[0]);
    return logic'(m_cpol[0]);
  endfunction

  function automatic logic exp_mosi();
    if (!m_busy) return 1'b0;
    if (x_cpha == 0) return m_txb[m_edges/2];
    if (m_edges == 0) return 1'b0;
    return m_txb[(m_edges+1)/2 - 1];
  endfunction

  function automatic logic [4:0] exp_cs();
    logic [4:0] v;
    v = 5'b11111;
    if (m_cs_on && x_sel < 5) v[x_sel] = 1'b0;
    return v;
  endfunction

  // per-cycle comparison away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !run_done) begin
      chk(sclk_o === exp_sclk(), "R4 sclk level", {31'b0, sclk_o}, {31'b0, exp_sclk()});
      chk(mosi_o === exp_mosi(), "R5/R6 mosi bit", {31'b0, mosi_o}, {31'b0, exp_mosi()});
      chk(cs_n_o === exp_cs(), "R8/R9 selects", {27'b0, cs_n_o}, {27'b0, exp_cs()});
      chk(irq_o === (m_flag && m_irqen != 0), "R10 irq", {31'b0, irq_o}, {31'b0, m_flag && m_irqen != 0});
    end
  end

  // ---------------- host tasks ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i); we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); we_i = 0; wdata_i = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk_i); addr_i = a; #1; v = rdata_o;
  endtask

  function automatic logic [31:0] mk(int len, int cpol, int cpha, int lsb, int sel, int hold, int ien, int div);
    return {8'b0, 8'(div), 6'b0, 1'(ien), 1'(hold), 3'(sel), 1'(lsb), 1'(cpha), 1'(cpol), 2'(len)};
  endfunction

  // runs one transfer, measures busy length and checks receive data
  task automatic xfer(input logic [31:0] ctrl, input logic [31:0] tx, input string tag);
    int cnt, lbits, hh;
    logic [31:0] v;
    lbits = (ctrl[1:0] == 0) ? 8 : (ctrl[1:0] == 1) ? 16 : 32;
    hh = (ctrl[23:16] == 0) ? 1 : int'(ctrl[23:16]);
    wr(3'd0, ctrl);
    wr(3'd1, tx);
    wr(3'd4, 32'h1);
    addr_i = 3'd3; #1;
    cnt = 0;
    while (rdata_o[0] && cnt < 5000) begin
      cnt++;
      @(negedge clk_i); #1;
    end
    chk(cnt == 2 * lbits * hh, {"R3 busy length ", tag}, cnt, 2 * lbits * hh);
    rd(3'd2, v);
    chk(v === m_rx, {"R6/R7 rx word ", tag}, v, m_rx);
    if (lbits < 32) chk((v >> lbits) == 0, {"R7 upper zero ", tag}, v >> lbits, 0);
    rd(3'd3, v);
    chk(v[1] === 1'b1, {"R10 done flag ", tag}, v, 32'h2);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v, c0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    @(negedge clk_i);
    chk(cs_n_o === 5'b11111, "R1 cs idle", cs_n_o, 5'b11111);
    chk(sclk_o === 1'b0 && mosi_o === 1'b0 && irq_o === 1'b0, "R1 serial outputs", {sclk_o, mosi_o, irq_o}, 0);
    rd(3'd0, v); chk(v === 0, "R1 ctrl reset", v, 0);
    rd(3'd3, v); chk(v === 0, "R1 status reset", v, 0);
    rd(3'd2, v); chk(v === 0, "R1 rx reset", v, 0);

    // R2 control readback
    c0 = mk(1, 1, 0, 1, 2, 0, 1, 7);
    wr(3'd0, c0); rd(3'd0, v); chk(v === c0, "R2 ctrl readback", v, c0);
    wr(3'd0, 0);

    // modes, lengths, orders, dividers
    xfer(mk(0, 0, 0, 0, 0, 0, 0, 0), 32'h0000_00A5, "m0 8b msb");
    xfer(mk(1, 1, 1, 1, 2, 0, 0, 3), 32'h0000_C3F1, "m3 16b lsb");
    xfer(mk(2, 0, 1, 0, 4, 0, 0, 1), 32'h9ABC_DEF0, "m1 32b msb");
    xfer(mk(0, 1, 0, 1, 1, 0, 0, 2), 32'hFFFF_FF3C, "m2 8b lsb");
    xfer(mk(3, 0, 0, 1, 3, 0, 0, 2), 32'h1234_5678, "len3 32b lsb");

    // R10 interrupt enable and clear
    xfer(mk(0, 0, 0, 0, 0, 0, 1, 1), 32'h0000_0055, "irq on");
    @(negedge clk_i); chk(irq_o === 1'b1, "R10 irq raised", irq_o, 1);
    wr(3'd3, 32'h2);
    @(negedge clk_i); chk(irq_o === 1'b0, "R10 irq cleared", irq_o, 0);
    rd(3'd3, v); chk(v[1] === 1'b0, "R10 flag cleared", v, 0);
    xfer(mk(0, 0, 0, 0, 0, 0, 0, 1), 32'h0000_0011, "irq masked");
    @(negedge clk_i); chk(irq_o === 1'b0, "R10 irq masked", irq_o, 0);
    wr(3'd3, 32'h2);

    // R9 hold across transfers
    xfer(mk(0, 0, 0, 0, 3, 1, 0, 1), 32'h0000_00C1, "hold a");
    @(negedge clk_i); chk(cs_n_o === 5'b10111, "R9 held after end", cs_n_o, 5'b10111);
    xfer(mk(1, 0, 0, 0, 3, 1, 0, 1), 32'h0000_BEEF, "hold b");
    chk(cs_n_o === 5'b10111, "R9 held after second", cs_n_o, 5'b10111);
    wr(3'd0, mk(0, 0, 0, 0, 3, 0, 0, 1));
    @(negedge clk_i); chk(cs_n_o === 5'b11111, "R9 released", cs_n_o, 5'b11111);

    // R8 out-of-range index asserts nothing
    wr(3'd0, mk(0, 0, 0, 0, 6, 0, 0, 2)); wr(3'd1, 32'h5A); wr(3'd4, 1);
    repeat (5) @(negedge clk_i);
    chk(cs_n_o === 5'b11111, "R8 invalid index", cs_n_o, 5'b11111);
    while (m_busy) @(negedge clk_i);

    // R11 start and ctrl write while busy are ignored
    c0 = mk(2, 0, 0, 0, 1, 0, 0, 2);
    wr(3'd0, c0); wr(3'd1, 32'h0F0F_1234); wr(3'd4, 1);
    wr(3'd4, 1);
    wr(3'd0, mk(0, 1, 1, 1, 4, 1, 1, 9));
    while (m_busy) @(negedge clk_i);
    rd(3'd0, v); chk(v === c0, "R11 ctrl write ignored", v, c0);
    rd(3'd2, v); chk(v === m_rx, "R11 rx after busy writes", v, m_rx);
    rd(3'd3, v); chk(v[0] === 1'b0, "R11 no restart", v, 0);
    repeat (4) @(negedge clk_i);
    summary();
  end
endmodule